// File: doc/BRIEF.md
# Two-Road Intersection Signal Controller

This block runs the lamps at a crossing of a busy main road (the highway) and a quiet side road (the farmroad). A four-phase state machine cycles through highway green, highway yellow, farmroad green and farmroad yellow. A built-in interval timer measures how long the current phase has been active. The highway keeps right of way until a minimum green time has run and a car is waiting on the farmroad. The farmroad then gets green, and it gives that green up as soon as its traffic is gone or its maximum green time has run. Each yellow phase lasts a fixed short interval.

The timer restarts on every phase change. It counts clock cycles up to the long interval and holds there. The short and long interval lengths are parameters in clock cycles. All six lamp outputs are decoded from the registered phase alone, so a change on the sensor input never reaches a lamp within the same cycle.

Top module: `tlc_intersection`

## Requirements
- R1: While `rst_n` is low, and right after its release, the highway lamp is green and the farmroad lamp is red. Reset acts asynchronously.
- R2: In every phase, exactly one of green, yellow and red is lit for each road.
- R3: Highway green is held while `car_waiting` is low, however long that lasts. When `car_waiting` is high from the start of the phase, highway green lasts LONG_CYCLES+1 clock cycles and highway yellow follows.
- R4: Highway yellow lasts SHORT_CYCLES+1 cycles and is followed by farmroad green.
- R5: Farmroad green ends one clock edge after `car_waiting` is seen low. It also ends after LONG_CYCLES+1 cycles while `car_waiting` stays high. Farmroad yellow follows in both cases.
- R6: Farmroad yellow lasts SHORT_CYCLES+1 cycles and is followed by highway green.
- R7: The interval count clears on each phase change and saturates at LONG_CYCLES. A car that arrives after highway green has already lasted past the long interval ends highway green at the next clock edge.
- R8: The lamps depend only on the registered phase. A change of `car_waiting` between clock edges leaves every lamp unchanged.
- R9: Highway red is lit exactly in the two farmroad phases, and farmroad red is lit exactly in the two highway phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| car_waiting | input | 1 | Farmroad vehicle sensor, high while a car is present |
| hwy_green | output | 1 | Highway green lamp |
| hwy_yellow | output | 1 | Highway yellow lamp |
| hwy_red | output | 1 | Highway red lamp |
| farm_green | output | 1 | Farmroad green lamp |
| farm_yellow | output | 1 | Farmroad yellow lamp |
| farm_red | output | 1 | Farmroad red lamp |

## Verification
The bench builds the block with SHORT_CYCLES=3 and LONG_CYCLES=8. With these values every phase length can be checked cycle by cycle, one boundary at a time. They also let a 20-cycle wait in highway green push the timer well into saturation, so the late-arriving-car case is reached. Both ways out of farmroad green are driven: the car stays until the long interval runs out, and the car leaves after one cycle.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  typedef enum logic [1:0] {
    PH_HWY_GO   = 2'd0,
    PH_HWY_WARN = 2'd1,
    PH_FRM_GO   = 2'd2,
    PH_FRM_WARN = 2'd3
  } phase_t;

  localparam int NUM_ROADS = 2;
  localparam int ROAD_HWY  = 0;
  localparam int ROAD_FRM  = 1;
endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CW = $clog2(LONG_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LONG_CYCLES);
  localparam logic [CW-1:0] SHORT_MARK = CW'(SHORT_CYCLES);

  logic [CW-1:0] ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ticks <= '0;
    else if (restart)      ticks <= '0;
    else if (ticks != LIMIT) ticks <= ticks + 1'b1;
  end

  assign short_done = (ticks >= SHORT_MARK);
  assign long_done  = (ticks >= LIMIT);

  initial begin
    if (LONG_CYCLES <= SHORT_CYCLES) $error("LONG_CYCLES must exceed SHORT_CYCLES");
  end

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ticks == '0));
  // R7
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && long_done) |=> long_done);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ticks <= LIMIT);
endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   car_waiting,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase,
  output logic   restart
);
  phase_t phase_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_HWY_GO:   if (long_done && car_waiting)  phase_nxt = PH_HWY_WARN;
      PH_HWY_WARN: if (short_done)                phase_nxt = PH_FRM_GO;
      PH_FRM_GO:   if (long_done || !car_waiting) phase_nxt = PH_FRM_WARN;
      PH_FRM_WARN: if (short_done)                phase_nxt = PH_HWY_GO;
      default:                                    phase_nxt = PH_HWY_GO;
    endcase
  end

  assign restart = (phase_nxt != phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_HWY_GO;
    else        phase <= phase_nxt;
  end

  // R3
  hwy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_GO && !car_waiting) |=> (phase == PH_HWY_GO));
  // R4
  hwy_warn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HWY_WARN && short_done) |=> (phase == PH_FRM_GO));
  // R5
  frm_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FRM_GO && !car_waiting) |=> (phase == PH_FRM_WARN));
  // R6
  frm_warn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FRM_WARN && short_done) |=> (phase == PH_HWY_GO));
endmodule

// File: rtl/tlc_lamp_decode.sv
module tlc_lamp_decode
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  output logic [2:0] hwy_lamps,
  output logic [2:0] frm_lamps
);
  // Per road: bit 2 green, bit 1 yellow, bit 0 red.
  logic [2:0] lamps [NUM_ROADS];

  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    localparam phase_t GO   = (r == ROAD_HWY) ? PH_HWY_GO   : PH_FRM_GO;
    localparam phase_t WARN = (r == ROAD_HWY) ? PH_HWY_WARN : PH_FRM_WARN;
    always_comb begin
      lamps[r][2] = (phase == GO);
      lamps[r][1] = (phase == WARN);
      lamps[r][0] = (phase != GO) && (phase != WARN);
    end
  end

  assign hwy_lamps = lamps[ROAD_HWY];
  assign frm_lamps = lamps[ROAD_FRM];

  // R2
  one_lamp_hwy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hwy_lamps) == 1);
  // R2
  one_lamp_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(frm_lamps) == 1);
  // R9
  cross_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_lamps[0] == (frm_lamps[2] || frm_lamps[1]));
endmodule

// File: rtl/tlc_intersection.sv
module tlc_intersection
  import tlc_pkg::*;
#(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car_waiting,
  output logic hwy_green,
  output logic hwy_yellow,
  output logic hwy_red,
  output logic farm_green,
  output logic farm_yellow,
  output logic farm_red
);
  phase_t     phase;
  logic       restart;
  logic       short_done;
  logic       long_done;
  logic [2:0] hwy_lamps;
  logic [2:0] frm_lamps;

  tlc_interval_timer #(
    .SHORT_CYCLES(SHORT_CYCLES),
    .LONG_CYCLES (LONG_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .short_done(short_done),
    .long_done (long_done)
  );

  tlc_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .car_waiting(car_waiting),
    .short_done (short_done),
    .long_done  (long_done),
    .phase      (phase),
    .restart    (restart)
  );

  tlc_lamp_decode u_lamps (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .hwy_lamps(hwy_lamps),
    .frm_lamps(frm_lamps)
  );

  assign {hwy_green, hwy_yellow, hwy_red}    = hwy_lamps;
  assign {farm_green, farm_yellow, farm_red} = frm_lamps;

  // R8
  lamps_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(phase) |-> $stable(hwy_lamps) && $stable(frm_lamps));
endmodule

// File: tb/tlc_intersection_tb.sv
module tlc_intersection_tb;
  localparam int SHORT = 3;
  localparam int LONG  = 8;

  localparam logic [2:0] GRN = 3'b100;
  localparam logic [2:0] YEL = 3'b010;
  localparam logic [2:0] RED = 3'b001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car = 1'b0;
  logic hg, hy, hr, fg, fy, fr;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tlc_intersection #(.SHORT_CYCLES(SHORT), .LONG_CYCLES(LONG)) u_dut (
    .clk(clk), .rst_n(rst_n), .car_waiting(car),
    .hwy_green(hg), .hwy_yellow(hy), .hwy_red(hr),
    .farm_green(fg), .farm_yellow(fy), .farm_red(fr)
  );

  task automatic check_lamps(input string tag, input logic [2:0] hw, input logic [2:0] fm);
    total++;
    if ({hg, hy, hr} !== hw || {fg, fy, fr} !== fm) begin
      bad++;
      $display("FAIL %s: hwy=%b farm=%b expected hwy=%b farm=%b",
               tag, {hg, hy, hr}, {fg, fy, fr}, hw, fm);
    end
  endtask

  // Checks the lamps for n consecutive negedges, ending one negedge later.
  task automatic dwell(input string tag, input int n, input logic [2:0] hw, input logic [2:0] fm);
    for (int i = 0; i < n; i++) begin
      check_lamps(tag, hw, fm);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    car = 1'b1;
    #5;
    check_lamps("R1 async reset", GRN, RED);
    @(negedge clk);
    check_lamps("R1 in reset", GRN, RED);
    car = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_lamps("R1 after release R2 R9", GRN, RED);
  endtask

  task automatic t_hold_then_late_car();
    dwell("R3 hold without car", 20, GRN, RED);
    car = 1'b1;
    #1;
    check_lamps("R8 sensor rise no lamp change", GRN, RED);
    @(negedge clk);
    check_lamps("R7 saturated timer late car", YEL, RED);
  endtask

  task automatic t_full_cycle_car_stays();
    dwell("R4 highway yellow", SHORT + 1, YEL, RED);
    dwell("R5 farm green long", LONG + 1, RED, GRN);
    dwell("R6 farm yellow", SHORT + 1, RED, YEL);
    dwell("R3 highway green min", LONG + 1, GRN, RED);
    check_lamps("R3 to highway yellow", YEL, RED);
  endtask

  task automatic t_car_leaves();
    check_lamps("R4 yellow start", YEL, RED);
    @(negedge clk);
    car = 1'b0;
    #1;
    check_lamps("R8 sensor fall no lamp change", YEL, RED);
    car = 1'b1;
    @(negedge clk);
    dwell("R4 yellow rest", SHORT - 1, YEL, RED);
    check_lamps("R4 to farm green", RED, GRN);
    car = 1'b0;
    @(negedge clk);
    check_lamps("R5 car gone", RED, YEL);
    dwell("R6 farm yellow", SHORT + 1, RED, YEL);
    check_lamps("R6 back to highway", GRN, RED);
    dwell("R3 hold again", 12, GRN, RED);
  endtask

  initial begin
    t_reset();
    t_hold_then_late_car();
    t_full_cycle_car_stays();
    t_car_leaves();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule